// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel that copies a programmed number of data units from a source address to a destination address. Software fills in the start addresses, the address behaviour of each side, the unit size and the unit count, and then switches the channel on. The channel moves one unit at a time. Each unit is a single bus read followed by a single bus write. After every unit the remaining count drops by one and each side's address either advances by the unit size or stays where it is. When the count runs out, the channel switches itself off, latches a sticky done flag and, if enabled, raises its interrupt line.

Units are paced in one of two ways. In software mode, each write of a one-shot trigger bit moves one unit. In hardware mode, one of eight peripheral request lines, picked by a field in the control word, paces the copy and the channel answers on an acknowledge line. Hardware mode has two sub-modes. In demand mode, units follow one another back to back for as long as the request stays high. In handshake mode, the acknowledge is held after each unit until the peripheral drops its request, and it is released two cycles after that.

The state machine has seven states: IDLE (off), WAIT (on, waiting for a request), READ (bus read outstanding), WRITE (bus write outstanding), HOLD (handshake, waiting for the request to fall), and REL1 and REL2 (the two release cycles of the handshake). Its transitions are:
- IDLE goes to WAIT on a start with a non-zero count. A start with a zero count stays in IDLE.
- WAIT goes to IDLE when the channel is off, and to READ when a request is present.
- READ goes to WRITE when the bus signals ready.
- WRITE, when the bus signals ready, goes to one of:
  - HOLD in handshake mode;
  - IDLE on the last unit;
  - READ in demand mode while the request is still high;
  - WAIT otherwise.
- HOLD goes to REL1 when the request falls.
- REL1 goes to REL2.
- REL2 goes to WAIT if the channel is still on, or to IDLE otherwise.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, all nine registers read zero, and `dack`, `m_rd`, `m_wr` and `irq` are low. The register indices are:
  - 0: source base
  - 1: source mode
  - 2: destination base
  - 3: destination mode
  - 4: control
  - 5: status
  - 6: current source
  - 7: current destination
  - 8: trigger
- R2: Writing the trigger register with bit 1 set while the channel is off loads the remaining count from control bits 19:0 and loads the current addresses from the 31-bit base registers. The channel then reads as busy (status bit 30) and trigger bit 1 reads one.
- R3: Each unit is one read at the current source address, followed by one write of the data that was read to the current destination address. Each access is held, with a stable address, until `m_ready` is seen high.
- R4: Control bits 21:20 give the unit size: 0 is byte, 1 is half-word, 2 is word. The size is driven on `m_size`, and an incrementing address advances by 1, 2 or 4 respectively, wrapping at 31 bits.
- R5: In each mode register, bit 0 set keeps that side's address fixed and bit 0 clear makes it increment. Bit 1 is driven on `m_periph` during that side's access.
- R6: The remaining count drops by one after each unit and reads back in status bits 19:0. The current addresses read back at indices 6 and 7.
- R7: When the count reaches zero, trigger bit 1 clears and the sticky flag in status bit 31 sets. Writing a one to status bit 31 clears the flag.
- R8: `irq` is high only while the flag is set and control bit 29 is one.
- R9: In software mode (control bit 23 clear), writing trigger bit 0 moves exactly one unit. Trigger bit 0 reads back zero once the unit has been taken, and `dack` stays low.
- R10: In hardware mode (control bit 23 set), only the request line selected by control bits 26:24 starts a unit. The other lines have no effect.
- R11: In demand mode (control bit 31 clear), if the request is still high when a unit finishes, the next read starts in the following cycle with `dack` kept high. If the request is low, the channel waits with `dack` low.
- R12: In handshake mode (control bit 31 set), `dack` stays high after a unit while the request stays high. It goes low on the third clock edge after the request is first seen low, and the next unit does not start before that.
- R13: Starting with a count of zero leaves the channel idle and off, with no bus access and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 4 | Register index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| dreq | input | 8 | Peripheral request lines |
| dack | output | 1 | Acknowledge to the selected peripheral |
| m_addr | output | 31 | Bus address |
| m_rd | output | 1 | Bus read request |
| m_wr | output | 1 | Bus write request |
| m_size | output | 2 | Unit size of the access |
| m_periph | output | 1 | Access targets the peripheral bus |
| m_wdata | output | 32 | Bus write data |
| m_rdata | input | 32 | Bus read data |
| m_ready | input | 1 | Bus access complete |
| irq | output | 1 | Done interrupt |

## Verification
The bench builds the block with its default parameters: a 31-bit address, 32-bit data, a 20-bit count and eight request lines. With these values all eight lines can be selected, and a word-incrementing source that starts just below the top of the 31-bit space wraps to zero, so the address-wrap corner is covered. The vector table crosses the three unit sizes with fixed and incrementing sides and with bus stalls of zero to three cycles. Directed tests then cover request-line selection, back-to-back chaining in demand mode, the two-cycle acknowledge release in handshake mode, and a start with a zero count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_REL1,
        ST_REL2
    } dma_state_t;

    localparam logic [3:0] RI_SRC_BASE = 4'd0;
    localparam logic [3:0] RI_SRC_MODE = 4'd1;
    localparam logic [3:0] RI_DST_BASE = 4'd2;
    localparam logic [3:0] RI_DST_MODE = 4'd3;
    localparam logic [3:0] RI_CTRL     = 4'd4;
    localparam logic [3:0] RI_STATUS   = 4'd5;
    localparam logic [3:0] RI_CUR_SRC  = 4'd6;
    localparam logic [3:0] RI_CUR_DST  = 4'd7;
    localparam logic [3:0] RI_TRIG     = 4'd8;

    localparam int CB_SIZE_LO = 20;
    localparam int CB_HW      = 23;
    localparam int CB_REQ_LO  = 24;
    localparam int CB_IRQ_EN  = 29;
    localparam int CB_HS      = 31;

    localparam int SB_BUSY = 30;
    localparam int SB_FLAG = 31;

    typedef struct packed {
        logic       hs;
        logic       irq_en;
        logic [2:0] req_src;
        logic       hw;
        logic [1:0] size;
    } ctrl_cfg_t;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 31
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fixed,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] next
);
    logic [1:0]        sz_eff;
    logic [ADDR_W-1:0] step;

    always_comb begin
        sz_eff = (size == 2'd3) ? 2'd2 : size;
        step   = ADDR_W'(1) << sz_eff;
        next   = fixed ? addr : addr + step;
    end
endmodule

// File: rtl/dma_csr.sv
module dma_csr
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 31,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_sel,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              st_busy,
    input  logic [CNT_W-1:0]  st_count,
    input  logic [ADDR_W-1:0] cur_src,
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic              clr_on,
    input  logic              set_flag,
    input  logic              sw_take,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic              src_fixed,
    output logic              src_periph,
    output logic              dst_fixed,
    output logic              dst_periph,
    output logic [CNT_W-1:0]  count_init,
    output ctrl_cfg_t         cfg,
    output logic              chan_on,
    output logic              sw_req,
    output logic              start,
    output logic              flag
);
    logic [ADDR_W-1:0] src_base_q, dst_base_q;
    logic [1:0]        src_mode_q, dst_mode_q;
    logic [31:0]       ctrl_q;
    logic              on_q, swreq_q, flag_q;
    logic [31:0]       status_w;

    assign start = reg_we && (reg_sel == RI_TRIG) && reg_wdata[1] && !on_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base_q <= '0;
            dst_base_q <= '0;
            src_mode_q <= '0;
            dst_mode_q <= '0;
            ctrl_q     <= '0;
            on_q       <= 1'b0;
            swreq_q    <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            if (reg_we) begin
                unique case (reg_sel)
                    RI_SRC_BASE: src_base_q <= reg_wdata[ADDR_W-1:0];
                    RI_SRC_MODE: src_mode_q <= reg_wdata[1:0];
                    RI_DST_BASE: dst_base_q <= reg_wdata[ADDR_W-1:0];
                    RI_DST_MODE: dst_mode_q <= reg_wdata[1:0];
                    RI_CTRL:     ctrl_q     <= reg_wdata;
                    RI_STATUS:   if (reg_wdata[SB_FLAG]) flag_q <= 1'b0;
                    RI_TRIG: begin
                        on_q    <= reg_wdata[1];
                        swreq_q <= reg_wdata[0];
                    end
                    default: ;
                endcase
            end
            if (sw_take)  swreq_q <= 1'b0;
            if (clr_on)   on_q    <= 1'b0;
            if (set_flag) flag_q  <= 1'b1;
        end
    end

    always_comb begin
        status_w                = '0;
        status_w[CNT_W-1:0]     = st_count;
        status_w[SB_BUSY]       = st_busy;
        status_w[SB_FLAG]       = flag_q;
    end

    always_comb begin
        unique case (reg_sel)
            RI_SRC_BASE: reg_rdata = 32'(src_base_q);
            RI_SRC_MODE: reg_rdata = 32'(src_mode_q);
            RI_DST_BASE: reg_rdata = 32'(dst_base_q);
            RI_DST_MODE: reg_rdata = 32'(dst_mode_q);
            RI_CTRL:     reg_rdata = ctrl_q;
            RI_STATUS:   reg_rdata = status_w;
            RI_CUR_SRC:  reg_rdata = 32'(cur_src);
            RI_CUR_DST:  reg_rdata = 32'(cur_dst);
            RI_TRIG:     reg_rdata = {30'd0, on_q, swreq_q};
            default:     reg_rdata = '0;
        endcase
    end

    assign src_base   = src_base_q;
    assign dst_base   = dst_base_q;
    assign src_fixed  = src_mode_q[0];
    assign src_periph = src_mode_q[1];
    assign dst_fixed  = dst_mode_q[0];
    assign dst_periph = dst_mode_q[1];
    assign count_init = ctrl_q[CNT_W-1:0];
    assign cfg.hs      = ctrl_q[CB_HS];
    assign cfg.irq_en  = ctrl_q[CB_IRQ_EN];
    assign cfg.req_src = ctrl_q[CB_REQ_LO+2:CB_REQ_LO];
    assign cfg.hw      = ctrl_q[CB_HW];
    assign cfg.size    = ctrl_q[CB_SIZE_LO+1:CB_SIZE_LO];
    assign chan_on    = on_q;
    assign sw_req     = swreq_q;
    assign flag       = flag_q;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 31,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int NREQ   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chan_on,
    input  logic              hw_mode,
    input  logic              hs_mode,
    input  logic [2:0]        req_src,
    input  logic [1:0]        size,
    input  logic [CNT_W-1:0]  count_init,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              src_fixed,
    input  logic              dst_fixed,
    input  logic              src_periph,
    input  logic              dst_periph,
    input  logic              sw_req,
    input  logic [NREQ-1:0]   dreq,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ready,
    output logic              sw_take,
    output logic              clr_on,
    output logic              set_flag,
    output logic              busy,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic              dack,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_rd,
    output logic              m_wr,
    output logic [1:0]        m_size,
    output logic              m_periph,
    output logic [DATA_W-1:0] m_wdata
);
    dma_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] side_cur [2];
    logic [ADDR_W-1:0] side_nxt [2];
    logic              side_fix [2];
    logic [DATA_W-1:0] data_q;
    logic              req_line, unit_req, last_unit, wr_done, rd_done;

    assign req_line  = dreq[req_src];
    assign unit_req  = hw_mode ? req_line : sw_req;
    assign last_unit = (cnt_q == CNT_W'(1));
    assign rd_done   = (state_q == ST_READ)  && m_ready;
    assign wr_done   = (state_q == ST_WRITE) && m_ready;

    assign side_fix[0] = src_fixed;
    assign side_fix[1] = dst_fixed;

    for (genvar s = 0; s < 2; s++) begin : g_side
        dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .addr  (side_cur[s]),
            .fixed (side_fix[s]),
            .size  (size),
            .next  (side_nxt[s])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && count_init != '0) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!chan_on)      state_d = ST_IDLE;
                else if (unit_req) state_d = ST_READ;
            end
            ST_READ:  if (m_ready) state_d = ST_WRITE;
            ST_WRITE: begin
                if (m_ready) begin
                    if (hw_mode && hs_mode)                  state_d = ST_HOLD;
                    else if (last_unit)                      state_d = ST_IDLE;
                    else if (hw_mode && req_line && chan_on) state_d = ST_READ;
                    else                                     state_d = ST_WAIT;
                end
            end
            ST_HOLD:  if (!req_line) state_d = ST_REL1;
            ST_REL1:  state_d = ST_REL2;
            ST_REL2:  state_d = chan_on ? ST_WAIT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        m_rd     = 1'b0;
        m_wr     = 1'b0;
        m_addr   = side_cur[0];
        m_periph = src_periph;
        dack     = 1'b0;
        sw_take  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: sw_take = chan_on && !hw_mode && sw_req;
            ST_READ: begin
                m_rd = 1'b1;
                dack = hw_mode;
            end
            ST_WRITE: begin
                m_wr     = 1'b1;
                m_addr   = side_cur[1];
                m_periph = dst_periph;
                dack     = hw_mode;
            end
            ST_HOLD, ST_REL1, ST_REL2: dack = hw_mode;
            default: ;
        endcase
        clr_on   = (start && count_init == '0) || (wr_done && last_unit);
        set_flag = wr_done && last_unit;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            side_cur[0] <= '0;
            side_cur[1] <= '0;
            data_q      <= '0;
        end else begin
            if (start) begin
                cnt_q       <= count_init;
                side_cur[0] <= src_base;
                side_cur[1] <= dst_base;
            end
            if (rd_done) data_q <= m_rdata;
            if (wr_done) begin
                cnt_q       <= cnt_q - CNT_W'(1);
                side_cur[0] <= side_nxt[0];
                side_cur[1] <= side_nxt[1];
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign cur_cnt = cnt_q;
    assign cur_src = side_cur[0];
    assign cur_dst = side_cur[1];
    assign m_size  = size;
    assign m_wdata = data_q;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 31,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int NREQ   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_sel,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NREQ-1:0]   dreq,
    output logic              dack,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_rd,
    output logic              m_wr,
    output logic [1:0]        m_size,
    output logic              m_periph,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ready,
    output logic              irq
);
    ctrl_cfg_t         cfg;
    logic [ADDR_W-1:0] src_base, dst_base, cur_src, cur_dst;
    logic [CNT_W-1:0]  count_init, cur_cnt;
    logic src_fixed, src_periph, dst_fixed, dst_periph;
    logic chan_on, sw_req, start, flag, busy, clr_on, set_flag, sw_take;

    dma_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_busy(busy), .st_count(cur_cnt), .cur_src(cur_src), .cur_dst(cur_dst),
        .clr_on(clr_on), .set_flag(set_flag), .sw_take(sw_take),
        .src_base(src_base), .dst_base(dst_base),
        .src_fixed(src_fixed), .src_periph(src_periph),
        .dst_fixed(dst_fixed), .dst_periph(dst_periph),
        .count_init(count_init), .cfg(cfg), .chan_on(chan_on),
        .sw_req(sw_req), .start(start), .flag(flag)
    );

    dma_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NREQ(NREQ)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_on(chan_on),
        .hw_mode(cfg.hw), .hs_mode(cfg.hs), .req_src(cfg.req_src), .size(cfg.size),
        .count_init(count_init), .src_base(src_base), .dst_base(dst_base),
        .src_fixed(src_fixed), .dst_fixed(dst_fixed),
        .src_periph(src_periph), .dst_periph(dst_periph),
        .sw_req(sw_req), .dreq(dreq), .m_rdata(m_rdata), .m_ready(m_ready),
        .sw_take(sw_take), .clr_on(clr_on), .set_flag(set_flag), .busy(busy),
        .cur_cnt(cur_cnt), .cur_src(cur_src), .cur_dst(cur_dst), .dack(dack),
        .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_size(m_size),
        .m_periph(m_periph), .m_wdata(m_wdata)
    );

    assign irq = flag && cfg.irq_en;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
    parameter int ADDR_W = 31,
    parameter int NREQ   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_rd,
    input logic              m_wr,
    input logic              m_ready,
    input logic [ADDR_W-1:0] m_addr,
    input logic              dack,
    input logic [NREQ-1:0]   dreq,
    input logic [2:0]        req_src,
    input logic              hw_mode,
    input logic              hs_mode,
    input logic              flag,
    input logic              chan_on
);
    logic req_line;
    assign req_line = dreq[req_src];

    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_rd && m_wr));

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd && !m_ready) |=> (m_rd && $stable(m_addr)));

    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr && !m_ready) |=> (m_wr && $stable(m_addr)));

    p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd && m_ready) |=> m_wr);

    p_hs_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode && hs_mode && dack && req_line && !m_rd && !m_wr) |=> dack);

    p_done_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> !chan_on);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W), .NREQ(NREQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_rd(m_rd), .m_wr(m_wr), .m_ready(m_ready),
    .m_addr(m_addr), .dack(dack), .dreq(dreq), .req_src(cfg.req_src),
    .hw_mode(cfg.hw), .hs_mode(cfg.hs), .flag(flag), .chan_on(chan_on)
);

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  dreq = '0;
    logic        dack;
    logic [30:0] m_addr;
    logic        m_rd, m_wr, m_periph, irq;
    logic [1:0]  m_size;
    logic [31:0] m_wdata, m_rdata;
    logic        m_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int ready_delay = 0;
    int wcnt = 0;
    int nw = 0;
    int nr = 0;
    logic [30:0] wl_addr [16];
    logic [31:0] wl_data [16];
    logic [1:0]  wl_size [16];
    logic        wl_per  [16];

    always #(CLK_NS/2) clk = ~clk;

    dma_chan_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
        .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_size(m_size),
        .m_periph(m_periph), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ready(m_ready), .irq(irq)
    );

    function automatic logic [31:0] mem_val(input logic [30:0] a);
        return {1'b0, a} + 32'h1000_0000;
    endfunction

    assign m_rdata = mem_val(m_addr);

    // bus responder and write monitor
    always @(posedge clk) begin
        if (m_wr && m_ready && nw < 16) begin
            wl_addr[nw] = m_addr;
            wl_data[nw] = m_wdata;
            wl_size[nw] = m_size;
            wl_per[nw]  = m_periph;
        end
        if (m_wr && m_ready) nw = nw + 1;
        if (m_rd && m_ready) nr = nr + 1;
        if ((m_rd || m_wr) && !m_ready) begin
            if (wcnt >= ready_delay) m_ready <= 1'b1;
            else wcnt = wcnt + 1;
        end else begin
            m_ready <= 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wait_nw(input int target, input string tag);
        for (int i = 0; i < 3000 && nw < target; i++) @(negedge clk);
        chk(nw >= target, tag, 32'(nw), 32'(target));
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic        sfix;
        logic        dfix;
        logic [7:0]  cnt;
        logic [3:0]  rdy;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] se;
        logic [31:0] de;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd0, 1'b0, 1'b0, 8'd4, 4'd0, 32'h0000_0100, 32'h0000_0200, 32'h0000_0104, 32'h0000_0204},
        '{2'd1, 1'b0, 1'b0, 8'd3, 4'd2, 32'h0000_1000, 32'h0000_2000, 32'h0000_1006, 32'h0000_2006},
        '{2'd2, 1'b1, 1'b0, 8'd5, 4'd1, 32'h0000_0040, 32'h0000_0800, 32'h0000_0040, 32'h0000_0814},
        '{2'd2, 1'b0, 1'b1, 8'd2, 4'd0, 32'h7FFF_FFF8, 32'h5500_0010, 32'h0000_0000, 32'h5500_0010},
        '{2'd0, 1'b1, 1'b1, 8'd1, 4'd3, 32'h0000_0003, 32'h0000_0005, 32'h0000_0003, 32'h0000_0005},
        '{2'd1, 1'b0, 1'b0, 8'd1, 4'd0, 32'h0000_0010, 32'h0000_0020, 32'h0000_0012, 32'h0000_0022}
    };

    initial begin
        #(CLK_NS * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < 9; r++) begin
            rd(4'(r), v);
            chk(v == 0, "R1 register reset value", v, 0);
        end
        chk(!dack && !m_rd && !m_wr && !irq, "R1 idle outputs", {dack, m_rd, m_wr, irq}, 0);

        // R13: zero count start
        base = nw;
        wr(4'd4, 32'h2000_0000);
        wr(4'd8, 32'h2);
        repeat (3) @(negedge clk);
        rd(4'd8, v); chk(v == 0, "R13 channel stays off", v, 0);
        rd(4'd5, v); chk(v == 0, "R13 status idle, no flag", v, 0);
        chk(nw == base && nr == 0, "R13 no bus access", 32'(nw + nr), 32'(base));

        // vector table: software-paced copies (R2..R9)
        for (int k = 0; k < 6; k++) begin
            int step;
            step = (VEC[k].sz == 2'd0) ? 1 : (VEC[k].sz == 2'd1) ? 2 : 4;
            ready_delay = int'(VEC[k].rdy);
            base = nw;
            wr(4'd0, VEC[k].src);
            wr(4'd1, {31'd0, VEC[k].sfix});
            wr(4'd2, VEC[k].dst);
            wr(4'd3, {30'd0, k[0], VEC[k].dfix});
            wr(4'd4, (32'(VEC[k].sz) << 20) | (32'd1 << 29) | 32'(VEC[k].cnt));
            wr(4'd8, 32'h2);
            rd(4'd5, v);
            chk(v[30] && v[19:0] == 20'(VEC[k].cnt), "R2 started busy with count", v, 32'(VEC[k].cnt));
            rd(4'd6, v);
            chk(v == {1'b0, VEC[k].src[30:0]}, "R2 current source loaded", v, VEC[k].src);
            for (int u = 0; u < int'(VEC[k].cnt); u++) begin
                wr(4'd8, 32'h3);
                wait_nw(base + u + 1, "R9 one unit per trigger");
                rd(4'd8, v);
                chk(v[0] == 1'b0, "R9 trigger bit self-clears", v, 0);
            end
            repeat (4) @(negedge clk);
            chk(nw == base + int'(VEC[k].cnt), "R9 exactly count units", 32'(nw - base), 32'(VEC[k].cnt));
            for (int u = 0; u < int'(VEC[k].cnt); u++) begin
                logic [30:0] ea, sa;
                ea = VEC[k].dfix ? VEC[k].dst[30:0] : VEC[k].dst[30:0] + 31'(u * step);
                sa = VEC[k].sfix ? VEC[k].src[30:0] : VEC[k].src[30:0] + 31'(u * step);
                chk(wl_addr[base + u] == ea, "R5 write address", 32'(wl_addr[base + u]), 32'(ea));
                chk(wl_data[base + u] == mem_val(sa), "R3 written data from read", wl_data[base + u], mem_val(sa));
                chk(wl_size[base + u] == VEC[k].sz, "R4 bus unit size", 32'(wl_size[base + u]), 32'(VEC[k].sz));
                chk(wl_per[base + u] == k[0], "R5 peripheral bus select", 32'(wl_per[base + u]), 32'(k[0]));
            end
            rd(4'd6, v); chk(v == VEC[k].se, "R6 current source end", v, VEC[k].se);
            rd(4'd7, v); chk(v == VEC[k].de, "R6 current destination end", v, VEC[k].de);
            rd(4'd5, v); chk(v == 32'h8000_0000, "R7 done: flag set, idle, count zero", v, 32'h8000_0000);
            rd(4'd8, v); chk(v == 0, "R7 channel turned off", v, 0);
            chk(irq == 1'b1, "R8 irq with enable", 32'(irq), 1);
            chk(dack == 1'b0, "R9 no acknowledge in software mode", 32'(dack), 0);
            wr(4'd5, 32'h8000_0000);
            rd(4'd5, v); chk(v == 0, "R7 flag write-one clear", v, 0);
            chk(irq == 1'b0, "R8 irq drops with flag", 32'(irq), 0);
        end
        ready_delay = 0;

        // R10: request line selection
        base = nw;
        wr(4'd0, 32'h300); wr(4'd1, 0); wr(4'd2, 32'h400); wr(4'd3, 0);
        wr(4'd4, (32'd1 << 23) | (32'd5 << 24) | (32'd1 << 20) | 32'd4);
        wr(4'd8, 32'h2);
        dreq[2] = 1'b1;
        repeat (10) @(negedge clk);
        chk(nw == base, "R10 unselected line ignored", 32'(nw), 32'(base));
        rd(4'd5, v); chk(v == 32'h4000_0004, "R10 still busy with full count", v, 32'h4000_0004);
        chk(dack == 1'b0, "R10 no acknowledge", 32'(dack), 0);
        dreq[2] = 1'b0;

        // R11: demand mode chaining and waiting
        dreq[5] = 1'b1;
        wait_nw(base + 2, "R11 demand units run");
        chk(m_rd && dack, "R11 next read chained at once", {m_rd, dack}, 2'b11);
        dreq[5] = 1'b0;
        wait_nw(base + 3, "R11 unit in flight completes");
        repeat (10) @(negedge clk);
        chk(nw == base + 3, "R11 waits without request", 32'(nw), 32'(base + 3));
        chk(dack == 1'b0, "R11 acknowledge low while waiting", 32'(dack), 0);
        rd(4'd5, v); chk(v == 32'h4000_0001, "R6 one unit remaining", v, 32'h4000_0001);
        dreq[5] = 1'b1;
        wait_nw(base + 4, "R11 resumes on request");
        dreq[5] = 1'b0;
        repeat (4) @(negedge clk);
        rd(4'd5, v); chk(v == 32'h8000_0000, "R7 demand run done", v, 32'h8000_0000);
        chk(irq == 1'b0, "R8 no irq without enable", 32'(irq), 0);
        rd(4'd7, v); chk(v == 32'h408, "R4 half-word destination step", v, 32'h408);
        wr(4'd5, 32'h8000_0000);

        // R12: handshake release timing
        base = nw;
        wr(4'd4, (32'd1 << 31) | (32'd1 << 23) | (32'd1 << 24) | (32'd2 << 20) | 32'd2);
        wr(4'd8, 32'h2);
        dreq[1] = 1'b1;
        wait_nw(base + 1, "R12 first handshake unit");
        repeat (5) @(negedge clk);
        chk(dack == 1'b1, "R12 acknowledge held while request high", 32'(dack), 1);
        chk(nw == base + 1 && !m_rd, "R12 no new unit during hold", 32'(nw), 32'(base + 1));
        dreq[1] = 1'b0;
        @(negedge clk); chk(dack == 1'b1, "R12 release cycle one", 32'(dack), 1);
        @(negedge clk); chk(dack == 1'b1, "R12 release cycle two", 32'(dack), 1);
        @(negedge clk); chk(dack == 1'b0, "R12 acknowledge released", 32'(dack), 0);
        rd(4'd5, v); chk(v == 32'h4000_0001, "R6 handshake count remaining", v, 32'h4000_0001);
        dreq[1] = 1'b1;
        wait_nw(base + 2, "R12 second handshake unit");
        dreq[1] = 1'b0;
        repeat (6) @(negedge clk);
        rd(4'd5, v); chk(v == 32'h8000_0000, "R7 handshake run done", v, 32'h8000_0000);
        chk(dack == 1'b0, "R12 idle after release", 32'(dack), 0);
        wr(4'd5, 32'h8000_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule